// File: doc/BRIEF.md
# Banked Non-Power-of-Two Single-Port RAM

This block is a single-port synchronous RAM whose word count does not have to be a power of two. Its storage is not one array spanning the whole address range. It is assembled from identical fixed-capacity banks, and it builds only as many banks as the configured depth needs. A 5000-word by 8-bit memory therefore uses five 8192-bit banks and not the eight that a 13-bit address would reach.

The high address bits choose a bank and the low bits choose the word inside it. Any address at or above the configured depth is treated as a hole in the map: a write there changes nothing, and a read there returns zero. Read data is registered. A bank index and an in-range flag are captured together with the bank read, and on the following cycle they steer the output multiplexer.

The synchronous reset clears only that steering state, so the output reads zero after reset. The stored words are left as they were.

Top module: `banked_ram`

## Requirements
- R1: With default parameters the word is 8 bits wide, the depth is 5000 words, the address is 13 bits wide and each bank holds 8192 bits (1024 words). A write happens on the rising clock edge when `wr_en_i` is 1 and the address is below 5000, and a later read of that address returns the written word.
- R2: Read data is registered. The word for the address sampled at a rising edge appears on `rd_data_o` after that edge and stays there until the next edge.
- R3: Address bits [12:10] select the bank and bits [9:0] select the word within it. Addresses that differ only in bank bits (for example 5, 1029, 2053, 3077 and 4101) hold independent words.
- R4: A write to an address from 5000 to 8191 is ignored. This covers bank indexes 5 to 7 and bank-4 offsets of 904 and above. No in-range word changes as a result.
- R5: A read of an address at or above 5000 returns all zeros on the next cycle, including when `wr_en_i` is 1 in that cycle.
- R6: When a write and a read target the same in-range address in one cycle, the read data on the next cycle is the newly written word (write-first).
- R7: While `rst_i` is 1 at a rising edge, `rd_data_o` is zero after that edge. Stored words survive the reset.
- R8: Both end words, address 0 and address 4999, are writable and readable. Address 5000 is the first address that is out of range.
- R9: A read with `wr_en_i` at 0 leaves the memory contents unchanged, so repeated reads return the same words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all activity on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset of the read steering state |
| wr_en_i | input | 1 | Write enable |
| addr_i | input | ADDR_W (13) | Word address |
| wr_data_i | input | WIDTH (8) | Data to write |
| rd_data_o | output | WIDTH (8) | Registered read data |

## Verification
A wrong bank decode shows up as aliasing: a word written through one bank becomes visible, or gets overwritten, at an address in a different bank. That error surfaces on the first read of the victim address, one cycle after that read is issued. A broken range mask either lets an out-of-range write corrupt a bank-4 word or a wrapped bank word, or lets nonzero data leak on an out-of-range read; the leak is visible on the very next cycle. A steering register that is delayed or not reset is exposed by every back-to-back read that crosses a bank, and by the zero expected just after reset.

// File: rtl/bram_pkg.sv
package bram_pkg;

    // Integer ceiling division used for bank counts.
    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    // Bits needed to index n items, never less than one.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Words per bank for a given bank capacity and word width.
    function automatic int unsigned words_per_bank(input int unsigned bank_bits, input int unsigned width);
        return (bank_bits / width == 0) ? 1 : bank_bits / width;
    endfunction

endpackage

// File: rtl/ram_addr_decode.sv
module ram_addr_decode #(
    parameter int unsigned ADDR_W     = 13,
    parameter int unsigned DEPTH      = 5000,
    parameter int unsigned BANK_WORDS = 1024,
    parameter int unsigned NUM_BANKS  = 5,
    parameter int unsigned SEL_W      = 3,
    parameter int unsigned OFS_W      = 10
) (
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    output logic                 hit_o,
    output logic [SEL_W-1:0]     bank_o,
    output logic [OFS_W-1:0]     ofs_o,
    output logic [NUM_BANKS-1:0] bank_we_o
);

    logic [31:0] addr_wide;

    always_comb begin
        addr_wide = 32'(addr_i);
        hit_o     = (addr_wide < DEPTH);
        bank_o    = SEL_W'(addr_wide / BANK_WORDS);
        ofs_o     = OFS_W'(addr_wide % BANK_WORDS);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
        assign bank_we_o[b] = wr_en_i && hit_o && (bank_o == SEL_W'(b));
    end

endmodule

// File: rtl/ram_bank.sv
module ram_bank #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned WORDS = 1024,
    parameter int unsigned OFS_W = 10
) (
    input  logic             clk_i,
    input  logic             we_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] store [WORDS];

    // Write-first: a write in this cycle is returned on the next one.
    always_ff @(posedge clk_i) begin
        if (we_i) begin
            store[ofs_i] <= wdata_i;
            rdata_o      <= wdata_i;
        end else begin
            rdata_o      <= store[ofs_i];
        end
    end

endmodule

// File: rtl/ram_read_sel.sv
module ram_read_sel #(
    parameter int unsigned WIDTH     = 8,
    parameter int unsigned NUM_BANKS = 5,
    parameter int unsigned SEL_W     = 3
) (
    input  logic                             clk_i,
    input  logic                             rst_i,
    input  logic                             hit_i,
    input  logic [SEL_W-1:0]                 bank_i,
    input  logic [NUM_BANKS-1:0][WIDTH-1:0]  bank_rdata_i,
    output logic [WIDTH-1:0]                 rd_data_o
);

    typedef struct packed {
        logic             hit;
        logic [SEL_W-1:0] bank;
    } steer_t;

    steer_t steer_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            steer_q <= '0;
        end else begin
            steer_q.hit  <= hit_i;
            steer_q.bank <= bank_i;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (steer_q.hit && steer_q.bank == SEL_W'(b)) begin
                rd_data_o = bank_rdata_i[b];
            end
        end
    end

endmodule

// File: rtl/banked_ram.sv
module banked_ram #(
    parameter int unsigned WIDTH     = 8,
    parameter int unsigned DEPTH     = 5000,
    parameter int unsigned BANK_BITS = 8192,
    parameter int unsigned ADDR_W    = bram_pkg::idx_bits(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]  wr_data_i,
    output logic [WIDTH-1:0]  rd_data_o
);

    localparam int unsigned BANK_WORDS = bram_pkg::words_per_bank(BANK_BITS, WIDTH);
    localparam int unsigned NUM_BANKS  = bram_pkg::ceil_div(DEPTH, BANK_WORDS);
    localparam int unsigned OFS_W      = bram_pkg::idx_bits(BANK_WORDS);
    localparam int unsigned SEL_W      = bram_pkg::idx_bits(NUM_BANKS);

    logic                            hit;
    logic [SEL_W-1:0]                bank;
    logic [OFS_W-1:0]                ofs;
    logic [NUM_BANKS-1:0]            bank_we;
    logic [NUM_BANKS-1:0][WIDTH-1:0] bank_rdata;

    ram_addr_decode #(
        .ADDR_W(ADDR_W), .DEPTH(DEPTH), .BANK_WORDS(BANK_WORDS),
        .NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W), .OFS_W(OFS_W)
    ) decode_i (
        .wr_en_i  (wr_en_i),
        .addr_i   (addr_i),
        .hit_o    (hit),
        .bank_o   (bank),
        .ofs_o    (ofs),
        .bank_we_o(bank_we)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ram_bank #(.WIDTH(WIDTH), .WORDS(BANK_WORDS), .OFS_W(OFS_W)) bank_i (
            .clk_i  (clk_i),
            .we_i   (bank_we[b]),
            .ofs_i  (ofs),
            .wdata_i(wr_data_i),
            .rdata_o(bank_rdata[b])
        );
    end

    ram_read_sel #(.WIDTH(WIDTH), .NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) rsel_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .hit_i       (hit),
        .bank_i      (bank),
        .bank_rdata_i(bank_rdata),
        .rd_data_o   (rd_data_o)
    );

    // R4: an address past the depth must never reach a bank write enable.
    p_oob_write_blocked_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (32'(addr_i) >= DEPTH) |-> (bank_we == '0));

    // R3: at most one bank is written per cycle.
    p_single_bank_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(bank_we));

    // R5: a read past the depth yields zero one cycle later.
    p_oob_read_zero_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (32'(addr_i) >= DEPTH) |=> (rd_data_o == '0));

    // R6: an in-range write is returned on the next cycle.
    p_write_first_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && (32'(addr_i) < DEPTH)) |=> (rd_data_o == $past(wr_data_i)));

endmodule

// File: tb/banked_ram_tb_top.sv
`timescale 1ns/1ps
module banked_ram_tb_top;

    localparam int WIDTH = 8;
    localparam int DEPTH = 5000;
    localparam int AW    = 13;

    logic             clk = 1'b0;
    logic             rst_i;
    logic             wr_en_i;
    logic [AW-1:0]    addr_i;
    logic [WIDTH-1:0] wr_data_i;
    logic [WIDTH-1:0] rd_data_o;

    int vectors = 0;
    int fails   = 0;
    logic [WIDTH-1:0] model [DEPTH];

    always #4 clk = ~clk;

    banked_ram dut_i (
        .clk_i    (clk),
        .rst_i    (rst_i),
        .wr_en_i  (wr_en_i),
        .addr_i   (addr_i),
        .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o)
    );

    task automatic check(input logic [WIDTH-1:0] exp, input string req, input int addr);
        vectors++;
        if (rd_data_o !== exp) begin
            fails++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", req, addr, rd_data_o, exp);
        end
    endtask

    // Drive one cycle at a falling edge, then compare at the next falling edge.
    task automatic step(input bit we, input int addr, input logic [WIDTH-1:0] d, input string req);
        logic [WIDTH-1:0] exp;
        wr_en_i   = we;
        addr_i    = AW'(addr);
        wr_data_i = d;
        if (addr >= DEPTH) exp = '0;
        else if (we) begin exp = d; model[addr] = d; end
        else exp = model[addr];
        @(negedge clk);
        check(exp, req, addr);
    endtask

    task automatic do_reset(input int cycles);
        rst_i = 1'b1;
        wr_en_i = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check('0, "R7", int'(addr_i));
        end
        rst_i = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst_i = 1'b1; wr_en_i = 1'b0; addr_i = '0; wr_data_i = '0;
        @(negedge clk);
        do_reset(3);

        // R1 / R6: fill every word; each write is echoed next cycle.
        for (int a = 0; a < DEPTH; a++) step(1'b1, a, WIDTH'((a * 7 + 3) ^ (a >> 8)), "R6");
        // R1: read a spread of words back.
        for (int a = 0; a < DEPTH; a += 97) step(1'b0, a, 8'h00, "R1");

        // R3: words that differ only in bank bits stay separate.
        for (int b = 0; b < 5; b++) step(1'b1, 5 + b * 1024, WIDTH'(8'h10 + b), "R3");
        for (int b = 4; b >= 0; b--) step(1'b0, 5 + b * 1024, 8'h00, "R3");

        // R4: out-of-range writes, including wrapped bank indexes and the bank-4 tail.
        step(1'b1, 6149, 8'hEE, "R4");
        step(1'b1, 7173, 8'hDD, "R4");
        step(1'b1, 5005, 8'hCC, "R4");
        step(1'b1, 8191, 8'hBB, "R4");
        step(1'b1, 5000, 8'hAA, "R4");
        step(1'b0, 5, 8'h00, "R4");
        step(1'b0, 1029, 8'h00, "R4");
        step(1'b0, 4101, 8'h00, "R4");
        step(1'b0, 909, 8'h00, "R4");
        step(1'b0, 1023, 8'h00, "R4");
        step(1'b0, 4999, 8'h00, "R4");

        // R5: out-of-range reads give zero, also with write enable high.
        step(1'b0, 5000, 8'h00, "R5");
        step(1'b0, 8191, 8'h00, "R5");
        step(1'b1, 6000, 8'h5A, "R5");
        step(1'b0, 4, 8'h00, "R5");

        // R8: both ends of the map.
        step(1'b1, 0, 8'hA5, "R8");
        step(1'b1, 4999, 8'h3C, "R8");
        step(1'b0, 0, 8'h00, "R8");
        step(1'b0, 4999, 8'h00, "R8");
        step(1'b0, 5000, 8'h00, "R8");

        // R2: back-to-back reads crossing banks; output follows one cycle later.
        for (int i = 0; i < 20; i++) step(1'b0, (i * 1237) % DEPTH, 8'h00, "R2");

        // R9: repeated reads return unchanged words.
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < 8; i++) step(1'b0, 600 + i * 511, 8'h00, "R9");

        // R7: reset mid-run zeroes output but keeps contents.
        do_reset(2);
        step(1'b0, 0, 8'h00, "R7");
        step(1'b0, 4999, 8'h00, "R7");

        // R1 / R2 / R6: random mix over the whole 13-bit space.
        for (int i = 0; i < 3000; i++) begin
            int a;
            a = int'($urandom_range(0, 8191));
            step($urandom_range(0, 1) == 1, a, WIDTH'($urandom), "R1");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule